// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast clock by a programmable integer using a two-ratio prescaler steered by two down-counters. At the start of each division cycle the prescaler divides by P+1 while the swallow count is nonzero. Once the swallow count is used up it divides by P for the rest of the cycle. The main count decides how many prescaler periods make up one cycle. The total ratio is B·P + A. The prescaler runs as synchronous logic on the same clock as the counters.

Software or a neighbouring control block presents a prescaler code, a swallow value A and a main value B on plain input buses. The divider latches them only when a cycle ends, so a cycle in progress always completes with the settings it started with. One single-clock pulse marks the end of every cycle. A flag reports when the settings in force cannot give B·P + A. The divider keeps running with such settings and follows a defined fallback ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: With 1 <= B and A <= B, the distance between consecutive `div_pulse` rising edges is exactly B·P + A clocks.
- R2: The prescaler code on `psel` selects the base modulus: 0 gives P=8, 1 gives P=16, 2 gives P=32, 3 gives P=64.
- R3: A=0 is legal and gives a ratio of exactly B·P. The swallow input is 6 bits wide, so values 0 to 63 are accepted.
- R4: The main input is 12 bits wide, values up to 4095. At the boundary A=B the ratio is B·(P+1).
- R5: `div_pulse` is high for exactly one clock per division cycle.
- R6: Changes on `psel`, `a_val` or `b_val` take effect only at the next cycle boundary. The cycle in progress keeps its length.
- R7: `cfg_err` is 1 while the settings in force have B < A or B = 0, and 0 otherwise. It changes only in the clock where `div_pulse` rises.
- R8: Settings that are invalid still give a periodic pulse. With B < A the ratio is B·(P+1). With B = 0 the ratio is P+1 if A > 0 and P if A = 0.
- R9: While `rst` is high, `div_pulse` is 0 and `cfg_err` reflects the inputs. The first pulse after reset rises exactly N clocks after the first clock edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads the current settings |
| psel | input | 2 | Prescaler code (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 12 | Main count B |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| cfg_err | output | 1 | Settings in force have B < A or B = 0 |

## Verification
The bench counts clocks between pulses for all four prescaler codes. It targets A=0, A=B and the largest B and A. A design that loaded the prescaler with the wrong modulus, or decremented the swallow count one period late, would miss B·P + A by a multiple of one clock or by a whole P. It also changes the settings right after a pulse. A divider that picked up new values mid-cycle would give one interval that matches neither the old ratio nor the new one. The invalid cases B < A and B = 0 check both the fallback ratio and the timing of the error flag. A wrong count-down could stall the divider or give a wrong period.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int A_W        = 6;
  localparam int B_W        = 12;
  localparam int PSEL_W     = 2;
  localparam int P_MIN_LOG2 = 3;
  // wide enough to hold the largest base modulus (P_MIN << (2**PSEL_W - 1))
  localparam int PRE_W      = P_MIN_LOG2 + (1 << PSEL_W);

  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic [A_W-1:0]    a;
    logic [B_W-1:0]    b;
  } div_cfg_t;

  function automatic logic [PRE_W-1:0] base_modulus(input logic [PSEL_W-1:0] code);
    logic [PRE_W-1:0] one;
    one = PRE_W'(1);
    return one << (P_MIN_LOG2 + int'(code));
  endfunction

  function automatic logic cfg_invalid(input div_cfg_t c);
    logic [B_W-1:0] a_ext;
    a_ext = {{(B_W-A_W){1'b0}}, c.a};
    return (c.b < a_ext) || (c.b == '0);
  endfunction
endpackage

// File: rtl/swallow_cfg_latch.sv
module swallow_cfg_latch
  import swallow_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reload,
  input  div_cfg_t cfg_in,
  output div_cfg_t cfg_q,
  output div_cfg_t cfg_eff,
  output logic     cfg_err
);
  // shadow copy only moves at a cycle boundary (or reset)
  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cfg_q   <= cfg_in;
      cfg_err <= cfg_invalid(cfg_in);
    end
  end

  // settings governing the next prescaler period
  assign cfg_eff = reload ? cfg_in : cfg_q;
endmodule

// File: rtl/swallow_counters.sv
module swallow_counters
  import swallow_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           tc,
  input  div_cfg_t       cfg_in,
  input  div_cfg_t       cfg_eff,
  output logic           reload,
  output logic           plus1_next,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt
);
  logic [A_W-1:0] a_next;
  logic [B_W-1:0] b_next;

  // last prescaler period of the cycle: main count at 1 (or 0 if B was 0)
  assign reload = tc && (b_cnt <= B_W'(1));

  always_comb begin
    a_next = a_cnt;
    b_next = b_cnt;
    if (reload) begin
      a_next = cfg_eff.a;
      b_next = cfg_eff.b;
    end else if (tc) begin
      a_next = (a_cnt != '0) ? a_cnt - A_W'(1) : a_cnt;
      b_next = b_cnt - B_W'(1);
    end
  end

  // swallow still pending => the coming period uses P+1
  assign plus1_next = (a_next != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= cfg_in.a;
      b_cnt <= cfg_in.b;
    end else begin
      a_cnt <= a_next;
      b_cnt <= b_next;
    end
  end
endmodule

// File: rtl/swallow_prescaler.sv
module swallow_prescaler
  import swallow_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t cfg_in,
  input  div_cfg_t cfg_eff,
  input  logic     plus1_next,
  output logic     tc
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] start_rst;
  logic [PRE_W-1:0] start_run;

  // load value = modulus - 1, where modulus is P or P+1
  assign start_rst = base_modulus(cfg_in.psel) - PRE_W'(1) + PRE_W'(cfg_in.a != '0);
  assign start_run = base_modulus(cfg_eff.psel) - PRE_W'(1) + PRE_W'(plus1_next);

  always_ff @(posedge clk) begin
    if (rst)     pre_cnt <= start_rst;
    else if (tc) pre_cnt <= start_run;
    else         pre_cnt <= pre_cnt - PRE_W'(1);
  end

  assign tc = (pre_cnt == '0);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import swallow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PSEL_W-1:0] psel,
  input  logic [A_W-1:0]    a_val,
  input  logic [B_W-1:0]    b_val,
  output logic              div_pulse,
  output logic              cfg_err
);
  div_cfg_t       cfg_in;
  div_cfg_t       cfg_q;
  div_cfg_t       cfg_eff;
  logic           tc;
  logic           reload;
  logic           plus1_next;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;

  assign cfg_in = '{psel: psel, a: a_val, b: b_val};

  swallow_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .reload(reload), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .cfg_eff(cfg_eff), .cfg_err(cfg_err)
  );

  swallow_counters u_cnt (
    .clk(clk), .rst(rst), .tc(tc), .cfg_in(cfg_in), .cfg_eff(cfg_eff),
    .reload(reload), .plus1_next(plus1_next), .a_cnt(a_cnt), .b_cnt(b_cnt)
  );

  swallow_prescaler u_pre (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_eff(cfg_eff),
    .plus1_next(plus1_next), .tc(tc)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= reload;
  end
endmodule

// File: rtl/swallow_chk.sv
module swallow_chk
  import swallow_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     div_pulse,
  input logic     cfg_err,
  input div_cfg_t cfg_q
);
  localparam int GAP_W = 8;
  localparam int MIN_RATIO = 1 << P_MIN_LOG2;

  logic             past_ok;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      gap     <= '0;
    end else begin
      past_ok <= 1'b1;
      if (div_pulse)       gap <= GAP_W'(1);
      else if (gap != '1)  gap <= gap + GAP_W'(1);
    end
  end

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  p_err_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$stable(cfg_err)) |-> div_pulse);

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$stable(cfg_q)) |-> div_pulse);

  p_gap_floor_r1: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (gap >= GAP_W'(MIN_RATIO)));
endmodule

bind pulse_swallow_div swallow_chk u_chk (
  .clk(clk), .rst(rst), .div_pulse(div_pulse), .cfg_err(cfg_err), .cfg_q(cfg_q)
);

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
module test_pulse_swallow_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  psel = '0;
  logic [5:0]  a_val = '0;
  logic [11:0] b_val = 12'd1;
  logic        div_pulse;
  logic        cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_swallow_div i_pulse_swallow_div (
    .clk(clk), .rst(rst), .psel(psel), .a_val(a_val), .b_val(b_val),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pval(input int code);
    return 8 << code;
  endfunction

  function automatic int ratio(input int code, input int a, input int b);
    int p = pval(code);
    if (b == 0)  return (a > 0) ? p + 1 : p;
    if (b < a)   return b * (p + 1);
    return b * p + a;
  endfunction

  function automatic bit bad(input int a, input int b);
    return (b < a) || (b == 0);
  endfunction

  task automatic apply(input int code, input int a, input int b);
    psel  = 2'(code);
    a_val = 6'(a);
    b_val = 12'(b);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse);
  endtask

  // apply settings, let them load at the next boundary, then time one cycle
  task automatic run_case(input int code, input int a, input int b, input string req);
    int n;
    apply(code, a, b);
    wait_pulse();
    check(cfg_err == bad(a, b), {req, " cfg_err"}, int'(cfg_err), int'(bad(a, b)));
    measure(n);
    check(n == ratio(code, a, b), req, n, ratio(code, a, b));
  endtask

  task automatic t_reset_r9();
    int n;
    rst = 1'b1;
    apply(1, 2, 3);
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R9 pulse low in reset", int'(div_pulse), 0);
    check(cfg_err == 1'b0, "R9 cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 1000);
    check(n == 50, "R9 first pulse distance", n, 50);
  endtask

  task automatic t_ratio_r1_r2();
    for (int c = 0; c < 4; c++) begin
      run_case(c, 5, 9, "R1 R2 ratio B=9 A=5");
      run_case(c, 1, 2, "R1 R2 ratio B=2 A=1");
    end
  endtask

  task automatic t_edges_r3_r4();
    run_case(2, 0, 6, "R3 A zero");
    run_case(3, 63, 63, "R4 A equals B");
    run_case(0, 63, 4095, "R4 B maximum");
  endtask

  task automatic t_width_r5();
    apply(0, 2, 3);
    wait_pulse();
    @(negedge clk);
    check(div_pulse == 1'b0, "R5 pulse width", int'(div_pulse), 0);
  endtask

  task automatic t_switch_r6();
    int n;
    run_case(1, 3, 4, "R6 setup");
    apply(3, 0, 2);
    measure(n);
    check(n == ratio(1, 3, 4), "R6 running cycle kept", n, ratio(1, 3, 4));
    check(cfg_err == 1'b0, "R6 cfg_err", int'(cfg_err), 0);
    measure(n);
    check(n == ratio(3, 0, 2), "R6 new setting applied", n, ratio(3, 0, 2));
  endtask

  task automatic t_invalid_r7_r8();
    run_case(0, 10, 4, "R8 R7 B below A");
    run_case(1, 5, 0, "R8 R7 B zero A nonzero");
    run_case(0, 0, 0, "R8 R7 B zero A zero");
    run_case(2, 4, 4, "R7 valid again");
  endtask

  initial begin
    t_reset_r9();
    t_ratio_r1_r2();
    t_width_r5();
    t_switch_r6();
    t_invalid_r7_r8();
    t_edges_r3_r4();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule